// File: doc/BRIEF.md
# Binarized Dot-Product Engine

This block finds the dot product of two vectors whose elements are ±1, the core step of a binarized neural-network layer. Activation and weight elements arrive 32 to a word, one word pair per accepted beat. Each element is one bit: 1 stands for +1 and 0 stands for -1. Each pair of bits is combined with XNOR, so a 1 marks a matching position. The matches in a word are counted and added into an accumulator across the beats of one vector. A per-beat mask marks which positions of a word hold real elements, so the last word of a vector may be partly filled.

When the last beat of a vector has passed through, the engine forms the signed sum. This is the number of matching positions minus the number of differing positions, which equals 2·matches − valid. The sum is multiplied by an unsigned Q8.8 scale factor, taken from a 64-entry table addressed by an output-channel index. The product is rounded to the nearest integer and saturated to a signed 32-bit result. Signed 8-bit activations can be fed instead through a built-in sign binarizer, which turns each lane into one bit before the XNOR.

Inputs use a valid/ready handshake. The result carries its own valid flag and waits until the downstream side accepts it.

Top module: `bxnor_dot`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: With every mask bit set, the signed sum S of a vector is the count of positions where the activation bit equals the weight bit, minus the count of positions where they differ. Bit 1 encodes +1 and bit 0 encodes -1.
- R3: A position whose in_mask bit is 0 adds nothing to S, neither as a match nor as a mismatch. An all-zero mask over the whole vector gives S = 0.
- R4: A beat with in_first=1 starts a new sum. Beats up to and including the one with in_last=1 add into that sum. Idle cycles between beats leave the partial sum unchanged.
- R5: out_data is floor((S·scale + 128) / 256), where scale is the unsigned Q8.8 entry selected by in_chan on the last beat. Halves therefore round toward +infinity. The result saturates to the signed 32-bit range.
- R6: A cycle with scale_we=1 writes scale_val into table entry scale_idx. Results formed after that write use the new value.
- R7: When the last beat is accepted in cycle t and the output is not stalled, out_valid is 1 in cycle t+2 and 0 in cycle t+1. Here t+1 means the first cycle after the accepting edge.
- R8: While out_valid=1 and out_ready=0, out_data and out_valid hold their values and in_ready is 0.
- R9: When in_raw_sel=1, lane i of in_raw (bits [8i+7:8i], two's complement) becomes activation bit i. A lane value ≥ 0, zero included, gives 1, and a negative value gives 0.
- R10: After a cycle with out_valid=1 and out_ready=1, out_valid falls to 0 unless a new result completes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scale_we | input | 1 | Scale table write strobe |
| scale_idx | input | 6 | Scale table entry to write |
| scale_val | input | 16 | Unsigned Q8.8 scale value |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Engine can take a beat |
| in_first | input | 1 | Beat starts a vector |
| in_last | input | 1 | Beat ends a vector |
| in_chan | input | 6 | Output channel, used on the last beat |
| in_raw_sel | input | 1 | Use the binarized in_raw instead of in_act |
| in_act | input | 32 | Packed activation bits |
| in_raw | input | 256 | 32 signed 8-bit activation lanes |
| in_wgt | input | 32 | Packed weight bits |
| in_mask | input | 32 | Valid-position mask for the beat |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | 32 | Scaled signed result |

## Verification
A wrong match count, or a mask that leaks, shows up as a wrong out_data two cycles after the last beat of that vector. A corrupted accumulator shows up in the same way, but only at the end of a multi-beat vector. A wrong scale table entry or a rounding error shows only on the channels and sums that reach it, so the stimulus covers odd sums on a half scale. A broken stall path shows at once: out_data changes while out_ready is low, or in_ready stays high during a stall.

// File: rtl/bxd_pkg.sv
package bxd_pkg;
  localparam int SCALE_FRAC = 8;
  localparam int LANE_W     = 8;
endpackage

// File: rtl/bxd_binarize.sv
module bxd_binarize #(
  parameter int LANES  = 32,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] raw,
  output logic [LANES-1:0]        bits
);
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      bits[i] = ~raw[i*LANE_W + LANE_W - 1];
    end
  end
endmodule

// File: rtl/bxd_popcnt.sv
module bxd_popcnt #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [W-1:0]  act,
  input  logic [W-1:0]  wgt,
  input  logic [W-1:0]  mask,
  output logic [CW-1:0] match_q,
  output logic [CW-1:0] valid_q
);
  logic [W-1:0]  hit;
  logic [CW-1:0] match_d, valid_d;

  always_comb begin
    hit     = ~(act ^ wgt) & mask;
    match_d = '0;
    valid_d = '0;
    for (int i = 0; i < W; i++) begin
      match_d = match_d + CW'(hit[i]);
      valid_d = valid_d + CW'(mask[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      valid_q <= '0;
    end else if (en) begin
      match_q <= match_d;
      valid_q <= valid_d;
    end
  end

  AST_MATCH_LE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    match_q <= valid_q); // R3
endmodule

// File: rtl/bxd_scale.sv
module bxd_scale #(
  parameter int CW = 13,
  parameter int SW = 16,
  parameter int OW = 32,
  parameter int FR = 8
) (
  input  logic [CW-1:0]        m,
  input  logic [CW-1:0]        n,
  input  logic [SW-1:0]        sc,
  output logic signed [OW-1:0] res
);
  localparam int DW = CW + 2;
  localparam int PW = DW + SW + 1;
  localparam logic signed [PW-1:0] HALF = {{(PW-FR){1'b0}}, 1'b1, {(FR-1){1'b0}}};
  localparam logic signed [PW-1:0] MAXV = {{(PW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = ~MAXV;

  logic signed [DW-1:0] dot;
  logic signed [PW-1:0] prod, rnd, shf;

  always_comb begin
    dot  = $signed({2'b00, m}) + $signed({2'b00, m}) - $signed({2'b00, n});
    prod = PW'(dot) * PW'($signed({1'b0, sc}));
    rnd  = prod + HALF;
    shf  = rnd >>> FR;
    if (shf > MAXV)      res = MAXV[OW-1:0];
    else if (shf < MINV) res = MINV[OW-1:0];
    else                 res = shf[OW-1:0];
  end
endmodule

// File: rtl/bxnor_dot.sv
module bxnor_dot #(
  parameter int WORD_W    = 32,
  parameter int MAX_ELEMS = 4096,
  parameter int NCH       = 64,
  parameter int SCALE_W   = 16,
  parameter int OUT_W     = 32,
  parameter int USE_BIN   = 1,
  localparam int CH_W  = $clog2(NCH),
  localparam int CNT_W = $clog2(WORD_W + 1),
  localparam int ACC_W = $clog2(MAX_ELEMS + 1),
  localparam int RAW_W = WORD_W * bxd_pkg::LANE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scale_we,
  input  logic [CH_W-1:0]         scale_idx,
  input  logic [SCALE_W-1:0]      scale_val,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_first,
  input  logic                    in_last,
  input  logic [CH_W-1:0]         in_chan,
  input  logic                    in_raw_sel,
  input  logic [WORD_W-1:0]       in_act,
  input  logic [RAW_W-1:0]        in_raw,
  input  logic [WORD_W-1:0]       in_wgt,
  input  logic [WORD_W-1:0]       in_mask,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_data
);
  logic              adv, take;
  logic [WORD_W-1:0] act_bits;
  logic [CNT_W-1:0]  pc_m, pc_n;
  logic              s1_valid, s1_first, s1_last;
  logic [CH_W-1:0]   s1_chan;
  logic [ACC_W-1:0]  acc_m, acc_n, sum_m, sum_n;
  logic [ACC_W-1:0]  acc_m_d, acc_n_d;
  logic              ov_d;
  logic signed [OUT_W-1:0] res, od_d;
  logic [SCALE_W-1:0] scale_mem [NCH];

  assign adv      = ~(out_valid & ~out_ready);
  assign in_ready = adv;
  assign take     = in_valid & adv;

  generate
    if (USE_BIN != 0) begin : g_bin
      logic [WORD_W-1:0] bin_bits;
      bxd_binarize #(.LANES(WORD_W), .LANE_W(bxd_pkg::LANE_W)) u_bin (
        .raw (in_raw),
        .bits(bin_bits)
      );
      assign act_bits = in_raw_sel ? bin_bits : in_act;
    end else begin : g_nobin
      assign act_bits = in_act;
    end
  endgenerate

  bxd_popcnt #(.W(WORD_W)) u_pop (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (adv),
    .act    (act_bits),
    .wgt    (in_wgt),
    .mask   (in_mask),
    .match_q(pc_m),
    .valid_q(pc_n)
  );

  always_ff @(posedge clk) begin
    if (scale_we) scale_mem[scale_idx] <= scale_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_chan  <= '0;
    end else if (adv) begin
      s1_valid <= take;
      s1_first <= in_first;
      s1_last  <= in_last;
      s1_chan  <= in_chan;
    end
  end

  always_comb begin
    sum_m = (s1_first ? '0 : acc_m) + ACC_W'(pc_m);
    sum_n = (s1_first ? '0 : acc_n) + ACC_W'(pc_n);
  end

  bxd_scale #(.CW(ACC_W), .SW(SCALE_W), .OW(OUT_W), .FR(bxd_pkg::SCALE_FRAC)) u_scale (
    .m  (sum_m),
    .n  (sum_n),
    .sc (scale_mem[s1_chan]),
    .res(res)
  );

  always_comb begin
    acc_m_d = acc_m;
    acc_n_d = acc_n;
    ov_d    = out_valid;
    od_d    = out_data;
    if (adv && s1_valid) begin
      if (s1_last) begin
        ov_d = 1'b1;
        od_d = res;
      end else begin
        acc_m_d = sum_m;
        acc_n_d = sum_n;
      end
    end
    if (out_valid && out_ready && !(s1_valid && s1_last)) ov_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_m     <= '0;
      acc_n     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      acc_m     <= acc_m_d;
      acc_n     <= acc_n_d;
      out_valid <= ov_d;
      out_data  <= od_d;
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_last) ##1 adv |=> out_valid); // R7
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_RISE_FROM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s1_valid && s1_last)); // R7
  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    acc_m <= acc_n); // R4
endmodule

// File: tb/sim_bxnor_dot.sv
module sim_bxnor_dot;
  localparam int CLK_P = 10;
  localparam int NV = 9;
  localparam logic [31:0] T_ACT  [NV] = '{32'hFFFFFFFF, 32'h00000000, 32'hA5A5A5A5, 32'h12345678,
                                          32'h00000000, 32'h00000001, 32'h00000000, 32'hDEADBEEF, 32'h00000000};
  localparam logic [31:0] T_WGT  [NV] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hA5A5A5A5, 32'h0F0F0F0F,
                                          32'h00000001, 32'h00000001, 32'h00000007, 32'hCAFEF00D, 32'hFFFFFFFF};
  localparam logic [31:0] T_MASK [NV] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h0000FFFF,
                                          32'h00000001, 32'h00000001, 32'h00000007, 32'hFFFFFFFF, 32'h80000001};
  localparam int T_CH [NV] = '{0, 0, 2, 2, 1, 1, 1, 63, 5};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scale_we = 1'b0;
  logic [5:0] scale_idx = '0;
  logic [15:0] scale_val = '0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_raw_sel = 1'b0;
  logic in_ready;
  logic [5:0] in_chan = '0;
  logic [31:0] in_act = '0, in_wgt = '0, in_mask = '0;
  logic [255:0] in_raw = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [31:0] out_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int sc_tab [64];

  always #(CLK_P/2) clk = ~clk;

  bxnor_dot u0 (
    .clk(clk), .rst_n(rst_n), .scale_we(scale_we), .scale_idx(scale_idx), .scale_val(scale_val),
    .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first), .in_last(in_last),
    .in_chan(in_chan), .in_raw_sel(in_raw_sel), .in_act(in_act), .in_raw(in_raw),
    .in_wgt(in_wgt), .in_mask(in_mask), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int beat_sum(input logic [31:0] a, input logic [31:0] w, input logic [31:0] m);
    int s = 0;
    for (int i = 0; i < 32; i++)
      if (m[i]) s += (a[i] == w[i]) ? 1 : -1;
    return s;
  endfunction

  function automatic longint scaled(input int s, input int sc);
    longint q = longint'(s) * longint'(sc) + 128;
    if (q >= 0) return q / 256;
    return -((-q + 255) / 256);
  endfunction

  task automatic wr_scale(input int idx, input int val);
    @(negedge clk);
    scale_we = 1'b1; scale_idx = 6'(idx); scale_val = 16'(val);
    sc_tab[idx] = val;
    @(posedge clk);
    @(negedge clk);
    scale_we = 1'b0;
  endtask

  task automatic beat(input logic [31:0] a, input logic [31:0] w, input logic [31:0] m,
                      input bit f, input bit l, input int ch);
    @(negedge clk);
    in_valid = 1'b1; in_act = a; in_wgt = w; in_mask = m;
    in_first = f; in_last = l; in_chan = 6'(ch);
    @(posedge clk);
  endtask

  task automatic finish_vec(input string tag, input longint exp);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R7 valid low at t+1"}, longint'(out_valid), 0);
    @(posedge clk);
    @(negedge clk);
    check({tag, " R7 valid high at t+2"}, longint'(out_valid), 1);
    check(tag, longint'(out_data), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s;
    logic signed [7:0] lane;
    logic [31:0] bb;
    logic signed [31:0] held;
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid in reset", longint'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R1 in_ready after reset", longint'(in_ready), 1);

    wr_scale(0, 256); wr_scale(1, 128); wr_scale(2, 384);
    wr_scale(5, 77);  wr_scale(63, 65535);

    // table walk: R2 matches minus mismatches, R3 masking, R5 rounding and scaling
    for (int k = 0; k < NV; k++) begin
      s = beat_sum(T_ACT[k], T_WGT[k], T_MASK[k]);
      beat(T_ACT[k], T_WGT[k], T_MASK[k], 1'b1, 1'b1, T_CH[k]);
      finish_vec($sformatf("R2 R3 R5 vector %0d", k), scaled(s, sc_tab[T_CH[k]]));
    end

    // R4: multi-beat vector with an idle gap and a partly filled tail word
    s = beat_sum(32'h13579BDF, 32'h2468ACE0, 32'hFFFFFFFF)
      + beat_sum(32'hFFFF0000, 32'h0000FFFF, 32'hFFFFFFFF)
      + beat_sum(32'h000000F0, 32'h000000FF, 32'h000000FF);
    beat(32'h13579BDF, 32'h2468ACE0, 32'hFFFFFFFF, 1'b1, 1'b0, 2);
    @(negedge clk); in_valid = 1'b0; @(posedge clk);
    @(negedge clk); @(posedge clk);
    beat(32'hFFFF0000, 32'h0000FFFF, 32'hFFFFFFFF, 1'b0, 1'b0, 2);
    beat(32'h000000F0, 32'h000000FF, 32'h000000FF, 1'b0, 1'b1, 0);
    finish_vec("R4 three beats with gap", scaled(s, sc_tab[0]));
    // R4: new first beat discards the earlier sum
    beat(32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0000000F, 1'b1, 1'b1, 0);
    finish_vec("R4 first clears sum", 4);

    // R6: rewrite a scale entry
    wr_scale(0, 512);
    beat(32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 0);
    finish_vec("R6 rewritten scale", 64);

    // R9: binarizer, zero maps to +1
    bb = '0;
    for (int i = 0; i < 32; i++) begin
      lane = (i == 0) ? 8'sd0 : (i == 1) ? -8'sd1 : (i == 2) ? 8'sd127 : (i == 3) ? -8'sd128 :
             (i % 2 == 0) ? 8'sd5 : -8'sd5;
      in_raw[i*8 +: 8] = lane;
      bb[i] = (lane >= 0);
    end
    s = beat_sum(bb, 32'hFFFFFFFF, 32'hFFFFFFFF);
    @(negedge clk); in_raw_sel = 1'b1;
    beat(32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 0);
    finish_vec("R9 binarized lanes", scaled(s, 512));
    beat(32'h00000000, 32'h00000001, 32'h00000001, 1'b1, 1'b1, 0);
    finish_vec("R9 zero lane is +1", 2);
    @(negedge clk); in_raw_sel = 1'b0;

    // R8: back-pressure holds the result
    out_ready = 1'b0;
    beat(32'h0000FFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 1);
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    held = out_data;
    check("R8 result during stall", longint'(out_data), scaled(0, 128));
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); @(negedge clk);
      check("R8 valid held", longint'(out_valid), 1);
      check("R8 data stable", longint'(out_data), longint'(held));
      check("R8 in_ready low", longint'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R10 valid drops after handshake", longint'(out_valid), 0);
    check("R8 in_ready back", longint'(in_ready), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule